// File: doc/BRIEF.md
# Multi-Channel Tamper Detection Controller

The block watches a set of tamper pins and one internal tamper event line. Every pin channel has its own two-bit action and its own polarity bit. An enabled edge channel reports the transition that its polarity selects. A channel in shield mode drives a pseudo-random bit out on its own output pin and expects to read the same bit back on its tamper pin. Any hit sets one shared interrupt flag and a sticky per-source identification bit. Hits from capture-mode and shield-mode channels also copy the free-running counter value into a timestamp register.

A four-state sequencer paces the shield. After reset, `SQ_PRIME` lasts one cycle. In that cycle the pin samples are loaded and nothing is detected (transition *arm*). Next comes `SQ_HOLD`, which waits `SHIELD_DIV` cycles (transition *div_done*). `SQ_STEP` then advances the pattern register (transition *advance*). In `SQ_CHECK` the returned pins are compared against the pattern (transition *compared*), and the sequencer goes back to `SQ_HOLD`. A full shield period is therefore `SHIELD_DIV+2` cycles. Because the compare happens in the cycle after the new pattern is driven, the pin round trip has one clock to settle.

Software clears the interrupt flag and the ID bits by writing ones to pulse inputs. Input synchronisation, glitch filtering and the counter itself are outside this block.

Top module: `tamper_watch`

## Requirements
- R1: Channel i takes its action from `cfg_action[2i+1:2i]`: 00 = off, 01 = wake, 10 = capture, 11 = shield. A channel that is off never sets its ID bit.
- R2: In wake mode, a transition on `tamp_in[i]` in the direction set by `cfg_level[i]` (1 = rising, 0 = falling) sets `id_bits[i]` and `irq_flag` on the clock edge that samples the new level. `stamp` is unchanged.
- R3: In capture mode, the same transition also loads `stamp` with the `count_in` value present in that cycle.
- R4: A transition opposite to the selected polarity is ignored, in both wake mode and capture mode.
- R5: In shield mode, `shield_out[i]` follows a pseudo-random pattern that advances once every `SHIELD_DIV+2` cycles. `tamp_in[i]` is compared with it in the cycle after each advance. A mismatch sets `id_bits[i]` and `irq_flag` and captures `stamp`. A returned value that matches never fires.
- R6: When `evt_en` is 1, a cycle with `evt_in` high sets `id_bits[4]` (bit N_CH) and `irq_flag` and does not touch `stamp`. When `evt_en` is 0, `evt_in` has no effect.
- R7: An ID bit stays set until a 1 is written to the same bit of `clr_id`. The clear acts on each bit separately. A new hit in the same cycle wins over the clear.
- R8: `irq_flag` stays set until `clr_flag` is pulsed. A hit in the same cycle as the clear leaves it set.
- R9: When several sources hit in one cycle, all of their ID bits are set and `stamp` is captured once, with that cycle's count.
- R10: Reset clears `irq_flag`, `id_bits` and `stamp`. In the first cycle after reset the pins are only sampled, so a pin that is already at its active level does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tamp_in | input | N_CH | Tamper pins (already synchronised) |
| shield_out | output | N_CH | Shield pattern driven per channel |
| count_in | input | CNT_W | Running counter value |
| cfg_action | input | 2*N_CH | Per-channel action field |
| cfg_level | input | N_CH | Per-channel polarity, 1 = rising |
| evt_in | input | 1 | Internal tamper event |
| evt_en | input | 1 | Enable for the event input |
| clr_flag | input | 1 | Write-one-to-clear for the interrupt flag |
| clr_id | input | N_CH+1 | Write-one-to-clear for the ID bits |
| irq_flag | output | 1 | Combined tamper interrupt flag |
| id_bits | output | N_CH+1 | Sticky source bits, event at the top |
| stamp | output | CNT_W | Captured counter value |

## Verification
The hardest case to reach from the ports is a shield mismatch. The compare instant is internal, and the pattern is pseudo-random, so the bench cannot predict either one. The bench therefore wires each shield pin back to its tamper input, optionally through an inverter. With the inverter off, the channel must stay silent across several periods. The inverter is then held on for one full period plus a cycle, which guarantees that a compare falls inside the window. The edge modes are swept over every channel, action, polarity and transition direction, and the expected result is computed for each combination.

// File: rtl/tamp_pkg.sv
package tamp_pkg;
    typedef enum logic [1:0] {
        ACT_OFF  = 2'b00,
        ACT_WAKE = 2'b01,
        ACT_CAPT = 2'b10,
        ACT_SHLD = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        SQ_PRIME,
        SQ_HOLD,
        SQ_STEP,
        SQ_CHECK
    } seq_e;
endpackage

// File: rtl/tamp_shield_seq.sv
module tamp_shield_seq
    import tamp_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int LFSR_W     = 8,
    parameter int SHIELD_DIV = 4,
    parameter logic [LFSR_W-1:0] SEED = 8'h5A,
    parameter logic [LFSR_W-1:0] TAPS = 8'hB8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            armed,
    output logic            check_en,
    output logic [N_CH-1:0] pattern
);
    localparam int DIV_W = $clog2(SHIELD_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SHIELD_DIV - 1);

    seq_e              state, state_nx;
    logic [DIV_W-1:0]  div_cnt;
    logic [LFSR_W-1:0] lfsr;
    logic              step_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_PRIME;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_PRIME: state_nx = SQ_HOLD;                       // arm
            SQ_HOLD:  if (div_cnt == DIV_LAST) state_nx = SQ_STEP; // div_done
            SQ_STEP:  state_nx = SQ_CHECK;                      // advance
            SQ_CHECK: state_nx = SQ_HOLD;                       // compared
            default:  state_nx = SQ_PRIME;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        armed    = 1'b1;
        check_en = 1'b0;
        step_en  = 1'b0;
        unique case (state)
            SQ_PRIME: armed    = 1'b0;
            SQ_HOLD:  ;
            SQ_STEP:  step_en  = 1'b1;
            SQ_CHECK: check_en = 1'b1;
            default:  armed    = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 div_cnt <= '0;
        else if (state == SQ_HOLD)  div_cnt <= div_cnt + 1'b1;
        else                        div_cnt <= '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       lfsr <= SEED;
        else if (step_en) lfsr <= {lfsr[LFSR_W-2:0], ^(lfsr & TAPS)};
    end

    assign pattern = lfsr[N_CH-1:0];
endmodule

// File: rtl/tamp_chan_det.sv
module tamp_chan_det
    import tamp_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              check_en,
    input  logic [N_CH-1:0]   tamp_in,
    input  logic [N_CH-1:0]   pattern,
    input  logic [2*N_CH-1:0] cfg_action,
    input  logic [N_CH-1:0]   cfg_level,
    output logic [N_CH-1:0]   hit,
    output logic [N_CH-1:0]   cap_hit
);
    logic [N_CH-1:0] prev;

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= tamp_in;
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        act_e act;
        logic edge_ok;
        logic mismatch;
        always_comb begin
            act      = act_e'(cfg_action[2*i +: 2]);
            edge_ok  = armed && (cfg_level[i] ? (!prev[i] && tamp_in[i])
                                              : (prev[i] && !tamp_in[i]));
            mismatch = check_en && (tamp_in[i] != pattern[i]);
            unique case (act)
                ACT_OFF:  begin hit[i] = 1'b0;     cap_hit[i] = 1'b0;     end
                ACT_WAKE: begin hit[i] = edge_ok;  cap_hit[i] = 1'b0;     end
                ACT_CAPT: begin hit[i] = edge_ok;  cap_hit[i] = edge_ok;  end
                ACT_SHLD: begin hit[i] = mismatch; cap_hit[i] = mismatch; end
                default:  begin hit[i] = 1'b0;     cap_hit[i] = 1'b0;     end
            endcase
        end
    end
endmodule

// File: rtl/tamp_record.sv
module tamp_record #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH:0]    src_hit,
    input  logic             capture,
    input  logic [CNT_W-1:0] count_in,
    input  logic             clr_flag,
    input  logic [N_CH:0]    clr_id,
    output logic             irq_flag,
    output logic [N_CH:0]    id_bits,
    output logic [CNT_W-1:0] stamp
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            id_bits  <= '0;
            stamp    <= '0;
        end else begin
            id_bits  <= (id_bits & ~clr_id) | src_hit;
            irq_flag <= (irq_flag & ~clr_flag) | (|src_hit);
            if (capture) stamp <= count_in;
        end
    end
endmodule

// File: rtl/tamper_watch.sv
module tamper_watch #(
    parameter int N_CH       = 4,
    parameter int CNT_W      = 16,
    parameter int LFSR_W     = 8,
    parameter int SHIELD_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   tamp_in,
    output logic [N_CH-1:0]   shield_out,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [2*N_CH-1:0] cfg_action,
    input  logic [N_CH-1:0]   cfg_level,
    input  logic              evt_in,
    input  logic              evt_en,
    input  logic              clr_flag,
    input  logic [N_CH:0]     clr_id,
    output logic              irq_flag,
    output logic [N_CH:0]     id_bits,
    output logic [CNT_W-1:0]  stamp
);
    logic            armed, check_en;
    logic [N_CH-1:0] ch_hit, ch_cap;

    tamp_shield_seq #(.N_CH(N_CH), .LFSR_W(LFSR_W), .SHIELD_DIV(SHIELD_DIV)) u_seq (
        .clk(clk), .rst_n(rst_n), .armed(armed), .check_en(check_en),
        .pattern(shield_out)
    );

    tamp_chan_det #(.N_CH(N_CH)) u_det (
        .clk(clk), .rst_n(rst_n), .armed(armed), .check_en(check_en),
        .tamp_in(tamp_in), .pattern(shield_out), .cfg_action(cfg_action),
        .cfg_level(cfg_level), .hit(ch_hit), .cap_hit(ch_cap)
    );

    tamp_record #(.N_CH(N_CH), .CNT_W(CNT_W)) u_rec (
        .clk(clk), .rst_n(rst_n),
        .src_hit({evt_in & evt_en, ch_hit}), .capture(|ch_cap),
        .count_in(count_in), .clr_flag(clr_flag), .clr_id(clr_id),
        .irq_flag(irq_flag), .id_bits(id_bits), .stamp(stamp)
    );
endmodule

// File: rtl/tamper_watch_chk.sv
module tamper_watch_chk #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2*N_CH-1:0] cfg_action,
    input logic              evt_en,
    input logic              clr_flag,
    input logic [N_CH:0]     clr_id,
    input logic              irq_flag,
    input logic [N_CH:0]     id_bits,
    input logic [CNT_W-1:0]  stamp
);
    logic any_cap_mode;
    always_comb begin
        any_cap_mode = 1'b0;
        for (int i = 0; i < N_CH; i++) any_cap_mode |= cfg_action[2*i+1];
    end

    a_r7_id_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(id_bits) & ~$past(clr_id)) & ~id_bits) == '0));

    a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !clr_flag) |=> irq_flag);

    a_r2_id_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((id_bits & ~$past(id_bits)) != '0) |-> irq_flag);

    a_r3_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !any_cap_mode |=> $stable(stamp));

    a_r6_event_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_en |=> !$rose(id_bits[N_CH]));

    for (genvar i = 0; i < N_CH; i++) begin : g_off
        a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_action[2*i +: 2] == 2'b00) |=> !$rose(id_bits[i]));
    end
endmodule

bind tamper_watch tamper_watch_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tamper_watch_tb.sv
module tamper_watch_tb;
    localparam int N_CH   = 4;
    localparam int CNT_W  = 16;
    localparam int DIV    = 4;
    localparam int PERIOD = DIV + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_CH-1:0]   tamp_in, shield_out;
    logic [N_CH-1:0]   pin_drv = '0, loop_sel = '0, inv = '0;
    logic [CNT_W-1:0]  count_in = '0;
    logic [2*N_CH-1:0] cfg_action = '0;
    logic [N_CH-1:0]   cfg_level = '0;
    logic              evt_in = 1'b0, evt_en = 1'b0, clr_flag = 1'b0;
    logic [N_CH:0]     clr_id = '0;
    logic              irq_flag;
    logic [N_CH:0]     id_bits;
    logic [CNT_W-1:0]  stamp;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;
    logic [CNT_W-1:0] exp_stamp = '0;

    always #5 clk = ~clk;

    assign tamp_in = (loop_sel & (shield_out ^ inv)) | (~loop_sel & pin_drv);

    tamper_watch #(.N_CH(N_CH), .CNT_W(CNT_W), .SHIELD_DIV(DIV)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_flag = 1'b1; clr_id = '1;
        @(negedge clk);
        clr_flag = 1'b0; clr_id = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R10: ch0 wake/rising with its pin already high through reset
        cfg_action = 8'b0000_0001; cfg_level = 4'b0001; pin_drv = 4'b0001;
        repeat (3) @(negedge clk);
        chk("R10 reset irq", 32'(irq_flag), 0);
        chk("R10 reset id", 32'(id_bits), 0);
        chk("R10 reset stamp", 32'(stamp), 0);
        rst_n = 1'b1;
        idle(4);
        chk("R10 no hit from primed high pin", 32'(id_bits), 0);
        cfg_action = '0; pin_drv = '0;
        idle(2);

        // R1..R4 sweep: channel x action (off/wake/capture) x level x direction
        for (int ch = 0; ch < N_CH; ch++)
            for (int act = 0; act < 3; act++)
                for (int lvl = 0; lvl < 2; lvl++)
                    for (int rise = 0; rise < 2; rise++) begin
                        bit fire;
                        logic [CNT_W-1:0] cnt;
                        fire = (act != 0) && (rise == lvl);
                        cnt  = CNT_W'(ch * 1000 + act * 100 + lvl * 10 + rise + 7);
                        @(negedge clk);
                        cfg_action = '0;
                        pin_drv = '0; pin_drv[ch] = (rise == 0);
                        idle(2);
                        cfg_action[2*ch +: 2] = 2'(act);
                        cfg_level = '0; cfg_level[ch] = lvl[0];
                        count_in = cnt;
                        clear_all();
                        pin_drv[ch] = (rise != 0);
                        @(negedge clk);
                        if (fire && act == 2) exp_stamp = cnt;
                        chk(act == 0 ? "R1 off id" : (fire ? "R2 id set" : "R4 wrong edge id"),
                            32'(id_bits), fire ? (32'd1 << ch) : 0);
                        chk(fire ? "R2 irq" : "R4 irq", 32'(irq_flag), 32'(fire));
                        chk(act == 2 ? "R3 capture stamp" : "R2 stamp held", 32'(stamp), 32'(exp_stamp));
                    end

        // R5 shield loopback per channel
        for (int ch = 0; ch < N_CH; ch++) begin
            @(negedge clk);
            cfg_action = '0; pin_drv = '0;
            loop_sel = '0; loop_sel[ch] = 1'b1; inv = '0;
            idle(1);
            cfg_action[2*ch +: 2] = 2'b11;
            idle(3 * PERIOD);
            clear_all();
            idle(2 * PERIOD);
            chk("R5 matched loopback silent", 32'(id_bits), 0);
            count_in = CNT_W'(16'h5000 + ch);
            inv[ch] = 1'b1;
            idle(PERIOD + 1);
            inv = '0;
            exp_stamp = count_in;
            chk("R5 mismatch id", 32'(id_bits), 32'd1 << ch);
            chk("R5 mismatch irq", 32'(irq_flag), 1);
            chk("R5 mismatch stamp", 32'(stamp), 32'(exp_stamp));
            cfg_action = '0;
            idle(1);
            loop_sel = '0;
        end

        // R6 event input
        idle(2);
        clear_all();
        count_in = 16'h7777;
        evt_en = 1'b0; evt_in = 1'b1;
        @(negedge clk); evt_in = 1'b0;
        @(negedge clk);
        chk("R6 event disabled id", 32'(id_bits), 0);
        chk("R6 event disabled irq", 32'(irq_flag), 0);
        evt_en = 1'b1; evt_in = 1'b1;
        @(negedge clk); evt_in = 1'b0;
        chk("R6 event id bit 4", 32'(id_bits), 32'h10);
        chk("R6 event irq", 32'(irq_flag), 1);
        chk("R6 event no capture", 32'(stamp), 32'(exp_stamp));
        evt_en = 1'b0;

        // R9 simultaneous hits
        clear_all();
        cfg_action = 8'b00_10_10_01; cfg_level = 4'b0101; pin_drv = 4'b0010;
        count_in = 16'h1234;
        idle(2);
        pin_drv = 4'b0101;
        @(negedge clk);
        chk("R9 all ids set", 32'(id_bits), 32'h07);
        chk("R9 single capture", 32'(stamp), 32'h1234);
        count_in = 16'h4321;

        // R7 sticky and per-bit clear
        idle(10);
        chk("R7 ids sticky", 32'(id_bits), 32'h07);
        clr_id = 5'b00001;
        @(negedge clk); clr_id = '0;
        chk("R7 per-bit clear", 32'(id_bits), 32'h06);
        clr_flag = 1'b1;
        @(negedge clk); clr_flag = 1'b0;
        chk("R8 flag cleared", 32'(irq_flag), 0);
        chk("R8 clear leaves ids", 32'(id_bits), 32'h06);
        chk("R9 stamp held after", 32'(stamp), 32'h1234);

        // R7/R8 set wins over clear in the same cycle (ch0 wake rising)
        pin_drv[0] = 1'b0;
        @(negedge clk);
        chk("R4 falling on rising channel ignored", 32'(id_bits), 32'h06);
        pin_drv[0] = 1'b1; clr_flag = 1'b1; clr_id = 5'b00001;
        @(negedge clk);
        clr_flag = 1'b0; clr_id = '0;
        chk("R8 set beats clear", 32'(irq_flag), 1);
        chk("R7 set beats clear", 32'(id_bits), 32'h07);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule